// File: doc/BRIEF.md
# Display RAM Address Pointer Unit

This block sits between a display controller's host data port and its display RAM. It holds the page and column pointer that every host data write and read uses. It advances the column after each access. It also generates the RAM read and write enables and the address, in the same cycle as the host strobe. In normal traversal, a column that reaches the last column is not wrapped straight away. The pointer stays on the last column and is cleared to column 0 only when the next access starts.

Host reads are served from a prefetch latch. The first read after a pointer change hands back whatever the latch held and loads the latch from the current location. Every later read returns the latch and refills it from the following location.

When window traversal is enabled, a rectangular window can be loaded. Accesses then walk the window column by column and page by page, and wrap back to its first corner. The RAM itself lives outside the block. The RAM has one cycle of read latency.

Top module: `dram_addr_unit`

## Requirements
- R1: After reset, the raw pointer is page 0, column 0, and no wrap is pending. `ram_we`, `ram_re` and `host_rvalid` are low, and the prefetch latch holds 0 with a dummy read required.
- R2: A host write drives `ram_we` in the same cycle. It drives `ram_addr` = {page, column} (page in the upper PAGE_W bits, column in the lower COL_W bits) and `ram_wdata` = `host_wdata`. Outside window traversal, the column then increases by one.
- R3: Outside window traversal, an access at the last column (127 by default) leaves the raw pointer on that column. The next access is made at column 0 of the same page, and the pointer advances from there.
- R4: The first read after reset, a pointer load, an accepted window load or a host write is a dummy read. It returns the latch contents held before that read and raises `ram_re` at the current effective address. The pointer does not advance.
- R5: Every other read returns the RAM data at the effective address, advances the pointer, and raises `ram_re` at the address that follows. Back-to-back reads on consecutive cycles return consecutive locations.
- R6: `host_rvalid` is high for exactly the cycle after an accepted read, with `host_rdata` valid in that cycle.
- R7: While `serial_mode` is high, `host_rd` is ignored: no `ram_re`, no `host_rvalid` and no pointer change.
- R8: `set_ptr` loads the pointer from `set_col` and `set_page` at the next edge and clears any pending wrap.
- R9: `win_load` is accepted only while `win_en` is high and both lower bounds are no greater than their upper bounds. An accepted load stores the bounds and moves the pointer to the lower column and lower page. Otherwise it is ignored.
- R10: During window traversal, an access at the upper column bound moves the pointer to the lower column bound and the next page. An access at the upper column and the upper page bound returns the pointer to the lower corner.
- R11: A pointer load or an accepted window load in the same cycle as a host strobe blocks the access. A write and a read in the same cycle perform only the write.
- R12: Outside window traversal, the page never changes on an access, including at the column wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| serial_mode | input | 1 | High when the host link is write-only |
| host_wr | input | 1 | One-cycle host data write strobe |
| host_wdata | input | DATA_W | Host write data |
| host_rd | input | 1 | One-cycle host data read strobe |
| host_rdata | output | DATA_W | Data returned to the host |
| host_rvalid | output | 1 | host_rdata valid this cycle |
| set_ptr | input | 1 | Load the pointer from set_col/set_page |
| set_col | input | COL_W | Column to load |
| set_page | input | PAGE_W | Page to load |
| win_en | input | 1 | Window traversal enable |
| win_load | input | 1 | Load window bounds |
| win_col_lo | input | COL_W | Window first column |
| win_col_hi | input | COL_W | Window last column |
| win_pg_lo | input | PAGE_W | Window first page |
| win_pg_hi | input | PAGE_W | Window last page |
| ram_addr | output | PAGE_W+COL_W | RAM address {page, column}; raw pointer when idle |
| ram_we | output | 1 | RAM write enable |
| ram_re | output | 1 | RAM read enable (data back one cycle later) |
| ram_wdata | output | DATA_W | RAM write data |
| ram_rdata | input | DATA_W | RAM read data |

## Verification
The hardest situation to reach is the deferred column wrap combined with the read prefetch. A read at the last column must refill the latch from column 0, while the raw pointer still reads back as the last column. The stimulus writes known bytes into the last two columns and into column 0 of a page, then reloads the pointer one column short of the end. It then issues a dummy read and three back-to-back reads. The bench checks the returned bytes, the refill address and the idle pointer between the accesses.

// File: rtl/dau_pkg.sv
// Package: shared types for the display RAM address pointer unit.
// Assumes nothing beyond the enclosing design.
package dau_pkg;

    // Kind of RAM access the unit performs in a cycle
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_DUMMY = 2'd2,
        ACC_READ  = 2'd3
    } acc_e;

endpackage

// File: rtl/dau_window.sv
// Module: dau_window
// Holds the window bounds used during window traversal and decides whether
// a window load request is accepted.
// Assumes: the bounds inputs are stable in the cycle win_load is high.
module dau_window #(
    parameter int COL_W  = 7,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_en,
    input  logic              win_load,
    input  logic [COL_W-1:0]  col_lo_in,
    input  logic [COL_W-1:0]  col_hi_in,
    input  logic [PAGE_W-1:0] pg_lo_in,
    input  logic [PAGE_W-1:0] pg_hi_in,
    output logic              accept,
    output logic [COL_W-1:0]  col_lo,
    output logic [COL_W-1:0]  col_hi,
    output logic [PAGE_W-1:0] pg_lo,
    output logic [PAGE_W-1:0] pg_hi
);

    logic [COL_W-1:0]  col_lo_q, col_hi_q;
    logic [PAGE_W-1:0] pg_lo_q, pg_hi_q;
    logic              bounds_ok;

    // Request is valid only with traversal enabled and ordered bounds
    always_comb begin
        bounds_ok = (col_lo_in <= col_hi_in) && (pg_lo_in <= pg_hi_in);
        accept    = win_en && win_load && bounds_ok;
    end

    // Bound registers, reset to the full RAM
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_lo_q <= '0;
            col_hi_q <= '1;
            pg_lo_q  <= '0;
            pg_hi_q  <= '1;
        end else if (accept) begin
            col_lo_q <= col_lo_in;
            col_hi_q <= col_hi_in;
            pg_lo_q  <= pg_lo_in;
            pg_hi_q  <= pg_hi_in;
        end
    end

    assign col_lo = col_lo_q;
    assign col_hi = col_hi_q;
    assign pg_lo  = pg_lo_q;
    assign pg_hi  = pg_hi_q;

    // R9: stored bounds stay ordered
    p_bounds_ordered_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (col_lo_q <= col_hi_q) && (pg_lo_q <= pg_hi_q));

    // R9: a load while traversal is off leaves the bounds alone
    p_load_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_en && win_load) |=> ($stable(col_lo_q) && $stable(col_hi_q)
                                   && $stable(pg_lo_q) && $stable(pg_hi_q)));

endmodule

// File: rtl/dau_ptr.sv
// Module: dau_ptr
// Page/column pointer with a deferred wrap at the last column during normal
// traversal and a wrap inside the window bounds during window traversal.
// Assumes: the window bounds are ordered (lo <= hi).
module dau_ptr #(
    parameter int COL_W  = 7,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [COL_W-1:0]  load_col,
    input  logic [PAGE_W-1:0] load_page,
    input  logic              win_mode,
    input  logic [COL_W-1:0]  win_col_lo,
    input  logic [COL_W-1:0]  win_col_hi,
    input  logic [PAGE_W-1:0] win_pg_lo,
    input  logic [PAGE_W-1:0] win_pg_hi,
    input  logic              access,
    input  logic              step,
    output logic [COL_W-1:0]  raw_col,
    output logic [PAGE_W-1:0] raw_page,
    output logic [COL_W-1:0]  eff_col,
    output logic [COL_W-1:0]  nxt_col,
    output logic [PAGE_W-1:0] nxt_page
);

    localparam logic [COL_W-1:0]  LAST_COL  = '1;
    localparam logic [PAGE_W-1:0] LAST_PAGE = '1;

    logic [COL_W-1:0]  col_q, col_adv;
    logic [PAGE_W-1:0] page_q, page_adv;
    logic              pend_q, pend_adv;

    // Effective column: a pending wrap means column 0
    always_comb begin
        eff_col = pend_q ? '0 : col_q;
    end

    // Successor of the effective address for the current traversal mode
    always_comb begin
        col_adv  = eff_col + 1'b1;
        page_adv = page_q;
        pend_adv = 1'b0;
        if (win_mode) begin
            if ((eff_col == win_col_hi) || (eff_col == LAST_COL)) begin
                col_adv  = win_col_lo;
                page_adv = ((page_q == win_pg_hi) || (page_q == LAST_PAGE))
                           ? win_pg_lo : page_q + 1'b1;
            end
        end else if (eff_col == LAST_COL) begin
            col_adv  = LAST_COL;
            pend_adv = 1'b1;
        end
        nxt_col  = pend_adv ? '0 : col_adv;
        nxt_page = page_adv;
    end

    // Pointer registers: load wins, then access (step or dummy)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q  <= '0;
            page_q <= '0;
            pend_q <= 1'b0;
        end else if (load) begin
            col_q  <= load_col;
            page_q <= load_page;
            pend_q <= 1'b0;
        end else if (access) begin
            if (step) begin
                col_q  <= col_adv;
                page_q <= page_adv;
                pend_q <= pend_adv;
            end else begin
                col_q  <= eff_col;
                pend_q <= 1'b0;
            end
        end
    end

    assign raw_col  = col_q;
    assign raw_page = page_q;

    // R3: a pending wrap only ever sits on the last column
    p_pend_on_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> (col_q == LAST_COL));

    // R2: normal step below the last column increments the column
    p_normal_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && access && step && !win_mode && eff_col != LAST_COL)
        |=> (col_q == $past(eff_col) + 1'b1));

    // R12: the page is held on any access outside window traversal
    p_page_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && access && !win_mode) |=> (page_q == $past(page_q)));

    // R10: stepping off the upper column bound lands on the lower bound
    p_win_col_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && access && step && win_mode && eff_col == win_col_hi)
        |=> (col_q == $past(win_col_lo)));

    // R8: a load takes effect at the next edge
    p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (col_q == $past(load_col) && page_q == $past(load_page)));

endmodule

// File: rtl/dau_rd_latch.sv
// Module: dau_rd_latch
// Prefetch latch for host reads, with the dummy-read flag and the host
// return register. Assumes a RAM read latency of exactly one cycle.
module dau_rd_latch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic              host_rd,
    input  logic              rearm,
    output logic              need_dummy,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid
);

    logic              fill_pend_q;
    logic [DATA_W-1:0] latch_q, latch_now, rdata_q;
    logic              rvalid_q, dummy_q;

    // Latch view with bypass of a refill that lands this cycle
    always_comb begin
        latch_now = fill_pend_q ? ram_rdata : latch_q;
    end

    // Track the RAM read in flight and capture its data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_pend_q <= 1'b0;
            latch_q     <= '0;
        end else begin
            fill_pend_q <= fill;
            latch_q     <= latch_now;
        end
    end

    // Dummy-read flag: set by pointer changes, cleared by a read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dummy_q <= 1'b1;
        end else if (rearm) begin
            dummy_q <= 1'b1;
        end else if (host_rd) begin
            dummy_q <= 1'b0;
        end
    end

    // Host return register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= host_rd;
            if (host_rd) begin
                rdata_q <= latch_now;
            end
        end
    end

    assign need_dummy  = dummy_q;
    assign host_rdata  = rdata_q;
    assign host_rvalid = rvalid_q;

    // R6: a read is answered in the following cycle
    p_rvalid_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd |=> host_rvalid);

    // R6: no answer without a read one cycle before
    p_no_spurious_rvalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> !host_rvalid);

    // R4: a read without a rearm leaves the dummy requirement met
    p_dummy_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !rearm) |=> !need_dummy);

endmodule

// File: rtl/dram_addr_unit.sv
// Module: dram_addr_unit (top)
// Arbitrates host strobes against pointer and window loads, and drives the
// RAM address and enables. It combines the pointer, the window bounds and
// the read prefetch latch. Assumes single-cycle strobes and a RAM with
// one cycle of read latency.
module dram_addr_unit #(
    parameter int COL_W  = 7,
    parameter int PAGE_W = 4,
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    serial_mode,
    input  logic                    host_wr,
    input  logic [DATA_W-1:0]       host_wdata,
    input  logic                    host_rd,
    output logic [DATA_W-1:0]       host_rdata,
    output logic                    host_rvalid,
    input  logic                    set_ptr,
    input  logic [COL_W-1:0]        set_col,
    input  logic [PAGE_W-1:0]       set_page,
    input  logic                    win_en,
    input  logic                    win_load,
    input  logic [COL_W-1:0]        win_col_lo,
    input  logic [COL_W-1:0]        win_col_hi,
    input  logic [PAGE_W-1:0]       win_pg_lo,
    input  logic [PAGE_W-1:0]       win_pg_hi,
    output logic [PAGE_W+COL_W-1:0] ram_addr,
    output logic                    ram_we,
    output logic                    ram_re,
    output logic [DATA_W-1:0]       ram_wdata,
    input  logic [DATA_W-1:0]       ram_rdata
);

    import dau_pkg::*;

    logic              win_accept, any_load, wr_go, rd_go, step, access;
    logic              need_dummy;
    logic [COL_W-1:0]  wcol_lo, wcol_hi, ld_col;
    logic [PAGE_W-1:0] wpg_lo, wpg_hi, ld_page;
    logic [COL_W-1:0]  raw_col, eff_col, nxt_col;
    logic [PAGE_W-1:0] raw_page, nxt_page;
    acc_e              acc;

    dau_window #(.COL_W(COL_W), .PAGE_W(PAGE_W)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_en    (win_en),
        .win_load  (win_load),
        .col_lo_in (win_col_lo),
        .col_hi_in (win_col_hi),
        .pg_lo_in  (win_pg_lo),
        .pg_hi_in  (win_pg_hi),
        .accept    (win_accept),
        .col_lo    (wcol_lo),
        .col_hi    (wcol_hi),
        .pg_lo     (wpg_lo),
        .pg_hi     (wpg_hi)
    );

    // Arbitration: loads block accesses; a write blocks a read
    always_comb begin
        any_load = set_ptr || win_accept;
        wr_go    = host_wr && !any_load;
        rd_go    = host_rd && !any_load && !host_wr && !serial_mode;
        access   = wr_go || rd_go;
        step     = wr_go || (rd_go && !need_dummy);
        ld_col   = win_accept ? win_col_lo : set_col;
        ld_page  = win_accept ? win_pg_lo  : set_page;
    end

    dau_ptr #(.COL_W(COL_W), .PAGE_W(PAGE_W)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (any_load),
        .load_col   (ld_col),
        .load_page  (ld_page),
        .win_mode   (win_en),
        .win_col_lo (wcol_lo),
        .win_col_hi (wcol_hi),
        .win_pg_lo  (wpg_lo),
        .win_pg_hi  (wpg_hi),
        .access     (access),
        .step       (step),
        .raw_col    (raw_col),
        .raw_page   (raw_page),
        .eff_col    (eff_col),
        .nxt_col    (nxt_col),
        .nxt_page   (nxt_page)
    );

    dau_rd_latch #(.DATA_W(DATA_W)) u_lat (
        .clk         (clk),
        .rst_n       (rst_n),
        .fill        (rd_go),
        .ram_rdata   (ram_rdata),
        .host_rd     (rd_go),
        .rearm       (any_load || wr_go),
        .need_dummy  (need_dummy),
        .host_rdata  (host_rdata),
        .host_rvalid (host_rvalid)
    );

    // Classify this cycle's RAM access
    always_comb begin
        if (wr_go)                  acc = ACC_WRITE;
        else if (rd_go && need_dummy) acc = ACC_DUMMY;
        else if (rd_go)             acc = ACC_READ;
        else                        acc = ACC_IDLE;
    end

    // RAM address mux by access kind
    always_comb begin
        case (acc)
            ACC_WRITE, ACC_DUMMY: ram_addr = {raw_page, eff_col};
            ACC_READ:             ram_addr = {nxt_page, nxt_col};
            default:              ram_addr = {raw_page, raw_col};
        endcase
        ram_we    = (acc == ACC_WRITE);
        ram_re    = (acc == ACC_DUMMY) || (acc == ACC_READ);
        ram_wdata = host_wdata;
    end

    // R11: never read and write the RAM in one cycle
    p_one_enable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && ram_re));

    // R7: no RAM read in write-only mode
    p_serial_no_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        serial_mode |-> !ram_re);

    // R11: a pointer load suppresses the write enable
    p_load_blocks_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        set_ptr |-> !ram_we);

endmodule

// File: tb/sim_dram_addr_unit.sv
`timescale 1ns/1ps
module sim_dram_addr_unit;

    localparam int COL_W  = 7;
    localparam int PAGE_W = 4;
    localparam int DATA_W = 8;
    localparam int AW     = PAGE_W + COL_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              serial_mode = 1'b0;
    logic              host_wr = 1'b0, host_rd = 1'b0;
    logic [DATA_W-1:0] host_wdata = '0;
    logic [DATA_W-1:0] host_rdata;
    logic              host_rvalid;
    logic              set_ptr = 1'b0;
    logic [COL_W-1:0]  set_col = '0;
    logic [PAGE_W-1:0] set_page = '0;
    logic              win_en = 1'b0, win_load = 1'b0;
    logic [COL_W-1:0]  win_col_lo = '0, win_col_hi = '0;
    logic [PAGE_W-1:0] win_pg_lo = '0, win_pg_hi = '0;
    logic [AW-1:0]     ram_addr;
    logic              ram_we, ram_re;
    logic [DATA_W-1:0] ram_wdata;
    logic [DATA_W-1:0] ram_rdata = '0;

    logic [DATA_W-1:0] mem [0:(1<<AW)-1];
    logic [DATA_W-1:0] exp_q [$];
    int                n_tests = 0;
    int                n_fail  = 0;

    always #4 clk = ~clk;

    dram_addr_unit #(.COL_W(COL_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .serial_mode(serial_mode),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .set_ptr(set_ptr), .set_col(set_col), .set_page(set_page),
        .win_en(win_en), .win_load(win_load),
        .win_col_lo(win_col_lo), .win_col_hi(win_col_hi),
        .win_pg_lo(win_pg_lo), .win_pg_hi(win_pg_hi),
        .ram_addr(ram_addr), .ram_we(ram_we), .ram_re(ram_re),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    // RAM model: synchronous write, one-cycle read latency
    initial begin
        for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
    end
    always @(posedge clk) begin
        if (ram_we) mem[ram_addr] <= ram_wdata;
        if (ram_re) ram_rdata <= mem[ram_addr];
    end

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int adr(input int pg, input int col);
        return (pg << COL_W) | col;
    endfunction

    // Scoreboard monitor: every host_rvalid pops one expected byte
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && host_rvalid) begin
                if (exp_q.size() == 0) begin
                    n_tests++; n_fail++;
                    $display("FAIL R7 actual=unexpected rvalid expected=none");
                end else begin
                    check("R5 read data", int'(host_rdata), int'(exp_q.pop_front()));
                end
            end
        end
    end

    // Each op task is entered at a negedge and returns at the next one
    task automatic clear_strobes();
        host_wr = 0; host_rd = 0; set_ptr = 0; win_load = 0;
    endtask

    task automatic idle(input string req, input int exp_addr);
        clear_strobes();
        #1;
        check(req, int'(ram_addr), exp_addr);
        @(negedge clk);
    endtask

    task automatic wr(input string req, input int d, input int exp_addr);
        clear_strobes();
        host_wr = 1; host_wdata = DATA_W'(d);
        #1;
        check({req, " we"}, int'(ram_we), 1);
        check({req, " addr"}, int'(ram_addr), exp_addr);
        @(negedge clk);
    endtask

    task automatic rd(input string req, input int exp_data, input int exp_addr);
        clear_strobes();
        host_rd = 1;
        #1;
        check({req, " re"}, int'(ram_re), 1);
        check({req, " addr"}, int'(ram_addr), exp_addr);
        exp_q.push_back(DATA_W'(exp_data));
        @(negedge clk);
    endtask

    task automatic setp(input int pg, input int col);
        clear_strobes();
        set_ptr = 1; set_col = COL_W'(col); set_page = PAGE_W'(pg);
        @(negedge clk);
    endtask

    task automatic wload(input int cl, input int ch, input int pl, input int ph);
        clear_strobes();
        win_load = 1;
        win_col_lo = COL_W'(cl); win_col_hi = COL_W'(ch);
        win_pg_lo = PAGE_W'(pl); win_pg_hi = PAGE_W'(ph);
        @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        #1;
        check("R1 addr", int'(ram_addr), 0);
        check("R1 we", int'(ram_we), 0);
        check("R1 re", int'(ram_re), 0);
        check("R1 rvalid", int'(host_rvalid), 0);
        @(negedge clk);

        // R8: pointer load
        setp(2, 5);
        idle("R8 load", adr(2, 5));

        // R2: writes advance the column
        wr("R2", 8'hA0, adr(2, 5));
        wr("R2", 8'hA1, adr(2, 6));
        wr("R2", 8'hA2, adr(2, 7));
        wr("R2", 8'hA3, adr(2, 8));
        idle("R2 after", adr(2, 9));

        // R4: dummy read returns reset latch value, pointer held
        setp(2, 5);
        rd("R4 dummy", 8'h00, adr(2, 5));
        idle("R4 held", adr(2, 5));
        // R5: back-to-back reads, refill at next address
        rd("R5", 8'hA0, adr(2, 6));
        rd("R5", 8'hA1, adr(2, 7));
        rd("R5", 8'hA2, adr(2, 8));
        idle("R5 after", adr(2, 8));
        // R6: answer arrives one cycle after the read
        check("R6 rvalid idle", int'(host_rvalid), 0);

        // R3: deferred wrap at the last column
        setp(3, 126);
        wr("R3", 8'hB1, adr(3, 126));
        wr("R3", 8'hB2, adr(3, 127));
        idle("R3 held at last", adr(3, 127));
        wr("R3 wrap", 8'hB3, adr(3, 0));
        idle("R3 after wrap", adr(3, 1));
        // R3/R4: reads across the wrap; dummy returns stale latch (A3)
        setp(3, 126);
        rd("R4 stale", 8'hA3, adr(3, 126));
        rd("R3 read", 8'hB1, adr(3, 127));
        rd("R3 read", 8'hB2, adr(3, 0));
        idle("R3 read held", adr(3, 127));
        rd("R3 read wrap", 8'hB3, adr(3, 1));
        idle("R3 read after", adr(3, 1));

        // R7: reads ignored in write-only mode
        serial_mode = 1;
        clear_strobes();
        host_rd = 1;
        #1;
        check("R7 re", int'(ram_re), 0);
        @(negedge clk);
        idle("R7 held", adr(3, 1));
        check("R7 rvalid", int'(host_rvalid), 0);
        serial_mode = 0;

        // R11: load blocks a write; write wins over read
        clear_strobes();
        set_ptr = 1; set_col = 7'd40; set_page = 4'd1; host_wr = 1;
        #1;
        check("R11 load blocks we", int'(ram_we), 0);
        @(negedge clk);
        idle("R11 loaded", adr(1, 40));
        clear_strobes();
        host_wr = 1; host_rd = 1; host_wdata = 8'hC0;
        #1;
        check("R11 we", int'(ram_we), 1);
        check("R11 re", int'(ram_re), 0);
        @(negedge clk);
        idle("R11 after", adr(1, 41));

        // R9: window load ignored while disabled or with bad bounds
        wload(10, 11, 4, 5);
        idle("R9 disabled", adr(1, 41));
        win_en = 1;
        wload(20, 10, 4, 5);
        idle("R9 bad bounds", adr(1, 41));
        wload(10, 11, 4, 5);
        idle("R9 accepted", adr(4, 10));

        // R10: traversal inside the window
        wr("R10", 8'hD0, adr(4, 10));
        wr("R10", 8'hD1, adr(4, 11));
        wr("R10", 8'hD2, adr(5, 10));
        wr("R10", 8'hD3, adr(5, 11));
        wr("R10", 8'hD4, adr(4, 10));
        idle("R10 after", adr(4, 11));

        // R12: normal traversal again keeps the page at the wrap
        win_en = 0;
        setp(6, 127);
        wr("R12", 8'hE0, adr(6, 127));
        wr("R12", 8'hE1, adr(6, 0));
        idle("R12 page held", adr(6, 1));

        repeat (4) @(negedge clk);
        check("R5 queue drained", exp_q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule